// File: doc/BRIEF.md
# Peripheral Enable and Soft-Reset Synchronizer

This block holds the control word of a peripheral whose working logic runs on its own clock. The bus side writes the word and reads it back. The enable bit and the software-reset bit are turned into commands. Each command crosses into the core clock domain on a single toggle-request / toggle-acknowledge channel, and each channel stage uses a multi-flop synchronizer. Two busy flags show on the bus side that a command is still in transit.

A written enable value shows in the read-back word on the edge that accepts the write. The enable busy flag stays high until the core has taken that value and the acknowledge has come back. More enable writes may arrive while one is in flight, and the last value written is the one the core ends up with. A software reset throws away the rest of its own write and clears the enable and configuration fields. It leaves a separate debug register alone. The reset bit stays set, together with its busy flag, until the core side has carried out the reset.

Top module: `ctl_enable_sync`

## Requirements
- R1: After `rst_bus` and `rst_core`, `rd_ctrl`, `rd_dbg`, `busy_enable`, `busy_swrst`, `core_enable` and `core_swrst` are all 0.
- R2: Bit 1 of the control word is the enable. A write that is not a reset loads it into `rd_ctrl[1]` on the accepting edge and raises `busy_enable` on the same edge. `busy_enable` falls only after `core_enable` holds the value.
- R3: Bits [CTRL_W-1:2] are configuration. A write stores them only if the enable bit was 0 before that write. Otherwise they keep their previous value.
- R4: Enable writes are accepted while `busy_enable` is high. `busy_enable` stays high until the last one is applied, and `core_enable` ends equal to the last value written.
- R5: A write with bit 0 set discards the other bits of the write. It clears the enable and configuration fields and clears `busy_enable`. It leaves `rd_dbg` unchanged. The core then sees a single-cycle `core_swrst` pulse with `core_enable` at 0.
- R6: `rd_ctrl[0]` and `busy_swrst` rise together on the accepting edge and fall together once the core has completed the reset.
- R7: A write with bit 0 clear starts no reset: `busy_swrst` stays 0 and no `core_swrst` pulse occurs.
- R8: Control writes made while `busy_swrst` is high are ignored.
- R9: The debug register is loaded only through `wr_dbg` and is cleared only by `rst_bus`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bus | input | 1 | Bus-side clock |
| rst_bus | input | 1 | Synchronous active-high reset, bus side |
| wr_ctrl | input | 1 | Control word write strobe |
| wr_ctrl_data | input | CTRL_W | Control word write data |
| wr_dbg | input | 1 | Debug register write strobe |
| wr_dbg_data | input | DBG_W | Debug register write data |
| rd_ctrl | output | CTRL_W | Control word read-back |
| rd_dbg | output | DBG_W | Debug register read-back |
| busy_enable | output | 1 | Enable command in transit |
| busy_swrst | output | 1 | Software reset in progress |
| clk_core | input | 1 | Core-side clock |
| rst_core | input | 1 | Synchronous active-high reset, core side |
| core_enable | output | 1 | Enable applied in the core domain |
| core_swrst | output | 1 | One-cycle reset pulse in the core domain |

## Verification
The read-back word and both busy flags are registered on the bus edge that accepts a write. The bench therefore checks them half a bus cycle after that edge, and it compares the read-back word with its model at every bus cycle. The round trip through the two clock domains takes a number of bus cycles that depends on the phase between the clocks. For that reason the bench does not predict when a busy flag falls. It waits for the fall within a bounded number of cycles and then checks `core_enable`, the read-back word and the count of `core_swrst` pulses, all of which have settled by then.

// File: rtl/ctl_sync_pkg.sv
package ctl_sync_pkg;
  localparam int unsigned SRST_BIT = 0;
  localparam int unsigned EN_BIT   = 1;
  localparam int unsigned CFG_LSB  = 2;

  typedef struct packed {
    logic rst;
    logic en;
  } cmd_t;
endpackage

// File: rtl/ctl_cdc_sync.sv
module ctl_cdc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b0;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/ctl_bus_regs.sv
module ctl_bus_regs
  import ctl_sync_pkg::*;
#(
  parameter int unsigned CFG_W = 6,
  parameter int unsigned DBG_W = 8,
  localparam int unsigned CTRL_W = CFG_W + CFG_LSB
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ctrl,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              wr_dbg,
  input  logic [DBG_W-1:0]  wr_dbg_data,
  input  logic              ack_sync,
  output logic [CTRL_W-1:0] rd_ctrl,
  output logic [DBG_W-1:0]  rd_dbg,
  output logic              busy_en_o,
  output logic              busy_rst_o,
  output logic              req_tgl_o,
  output cmd_t              cmd_o
);
  logic             ctrl_en;
  logic [CFG_W-1:0] ctrl_cfg;
  logic             busy_en, busy_rst;
  logic [DBG_W-1:0] dbg_q;
  logic             req_tgl, inflight, pend_en, pend_rst;
  cmd_t             cmd_q;

  logic srst_acc, en_acc, done, free;
  logic launch_rst, launch_en;
  logic ctrl_en_n;
  logic [CFG_W-1:0] ctrl_cfg_n;

  always_comb begin
    srst_acc   = wr_ctrl && !busy_rst && wr_data[SRST_BIT];
    en_acc     = wr_ctrl && !busy_rst && !wr_data[SRST_BIT];
    done       = inflight && (ack_sync == req_tgl);
    free       = !inflight || done;
    launch_rst = free && (pend_rst || srst_acc);
    launch_en  = free && !launch_rst && !srst_acc && !pend_rst && (pend_en || en_acc);
    ctrl_en_n  = ctrl_en;
    ctrl_cfg_n = ctrl_cfg;
    if (srst_acc) begin
      ctrl_en_n  = 1'b0;
      ctrl_cfg_n = '0;
    end else if (en_acc) begin
      ctrl_en_n = wr_data[EN_BIT];
      if (!ctrl_en) ctrl_cfg_n = wr_data[CTRL_W-1:CFG_LSB];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_en  <= 1'b0;
      ctrl_cfg <= '0;
      busy_en  <= 1'b0;
      busy_rst <= 1'b0;
      dbg_q    <= '0;
      req_tgl  <= 1'b0;
      inflight <= 1'b0;
      pend_en  <= 1'b0;
      pend_rst <= 1'b0;
      cmd_q    <= '0;
    end else begin
      ctrl_en  <= ctrl_en_n;
      ctrl_cfg <= ctrl_cfg_n;
      if (wr_dbg) dbg_q <= wr_dbg_data;

      if (srst_acc)                      busy_rst <= 1'b1;
      else if (done && cmd_q.rst)        busy_rst <= 1'b0;

      if (srst_acc)                      busy_en <= 1'b0;
      else if (en_acc)                   busy_en <= 1'b1;
      else if (done && !cmd_q.rst && !pend_en) busy_en <= 1'b0;

      pend_rst <= (pend_rst || srst_acc) && !launch_rst;
      pend_en  <= srst_acc ? 1'b0 : ((pend_en || en_acc) && !launch_en);

      if (launch_rst || launch_en) begin
        req_tgl   <= ~req_tgl;
        inflight  <= 1'b1;
        cmd_q.rst <= launch_rst;
        cmd_q.en  <= launch_rst ? 1'b0 : ctrl_en_n;
      end else if (done) begin
        inflight <= 1'b0;
      end
    end
  end

  assign rd_ctrl    = {ctrl_cfg, ctrl_en, busy_rst};
  assign rd_dbg     = dbg_q;
  assign busy_en_o  = busy_en;
  assign busy_rst_o = busy_rst;
  assign req_tgl_o  = req_tgl;
  assign cmd_o      = cmd_q;

  // R2
  busy_set_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_ctrl && !busy_rst && !wr_data[SRST_BIT]) |=> busy_en);

  // R3
  cfg_locked_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_en && !(wr_ctrl && wr_data[SRST_BIT])) |=> $stable(ctrl_cfg));

  // R5
  srst_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_ctrl && wr_data[SRST_BIT] && !busy_rst) |=> (!ctrl_en && ctrl_cfg == '0 && busy_rst && !busy_en));

  // R6
  rst_done_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_rst) |-> ($past(inflight) && $past(cmd_q.rst) && $past(ack_sync) == $past(req_tgl)));

  // R8
  ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_ctrl && busy_rst) |=> ($stable(ctrl_en) && $stable(ctrl_cfg)));
endmodule

// File: rtl/ctl_core_apply.sv
module ctl_core_apply
  import ctl_sync_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req_sync,
  input  cmd_t cmd_i,
  output logic ack_tgl_o,
  output logic core_enable_o,
  output logic core_swrst_o
);
  logic req_seen, en_q, srst_q;
  logic new_cmd;

  assign new_cmd = req_sync != req_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_seen <= 1'b0;
      en_q     <= 1'b0;
      srst_q   <= 1'b0;
    end else begin
      req_seen <= req_sync;
      srst_q   <= new_cmd && cmd_i.rst;
      if (new_cmd) en_q <= cmd_i.rst ? 1'b0 : cmd_i.en;
    end
  end

  assign ack_tgl_o     = req_seen;
  assign core_enable_o = en_q;
  assign core_swrst_o  = srst_q;

  // R5
  core_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    srst_q |=> !srst_q);

  // R5
  core_rst_dis_chk: assert property (@(posedge clk) disable iff (rst)
    srst_q |-> !en_q);
endmodule

// File: rtl/ctl_enable_sync.sv
module ctl_enable_sync
  import ctl_sync_pkg::*;
#(
  parameter int unsigned CFG_W       = 6,
  parameter int unsigned DBG_W       = 8,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CTRL_W     = CFG_W + CFG_LSB
) (
  input  logic              clk_bus,
  input  logic              rst_bus,
  input  logic              wr_ctrl,
  input  logic [CTRL_W-1:0] wr_ctrl_data,
  input  logic              wr_dbg,
  input  logic [DBG_W-1:0]  wr_dbg_data,
  output logic [CTRL_W-1:0] rd_ctrl,
  output logic [DBG_W-1:0]  rd_dbg,
  output logic              busy_enable,
  output logic              busy_swrst,
  input  logic              clk_core,
  input  logic              rst_core,
  output logic              core_enable,
  output logic              core_swrst
);
  logic req_tgl, req_core, ack_tgl, ack_bus;
  cmd_t cmd;

  ctl_bus_regs #(.CFG_W(CFG_W), .DBG_W(DBG_W)) u_bus (
    .clk        (clk_bus),
    .rst        (rst_bus),
    .wr_ctrl    (wr_ctrl),
    .wr_data    (wr_ctrl_data),
    .wr_dbg     (wr_dbg),
    .wr_dbg_data(wr_dbg_data),
    .ack_sync   (ack_bus),
    .rd_ctrl    (rd_ctrl),
    .rd_dbg     (rd_dbg),
    .busy_en_o  (busy_enable),
    .busy_rst_o (busy_swrst),
    .req_tgl_o  (req_tgl),
    .cmd_o      (cmd)
  );

  ctl_cdc_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk (clk_core),
    .rst (rst_core),
    .din (req_tgl),
    .dout(req_core)
  );

  ctl_core_apply u_core (
    .clk          (clk_core),
    .rst          (rst_core),
    .req_sync     (req_core),
    .cmd_i        (cmd),
    .ack_tgl_o    (ack_tgl),
    .core_enable_o(core_enable),
    .core_swrst_o (core_swrst)
  );

  ctl_cdc_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk (clk_bus),
    .rst (rst_bus),
    .din (ack_tgl),
    .dout(ack_bus)
  );
endmodule

// File: tb/ctl_enable_sync_test.sv
`timescale 1ns/1ps
module ctl_enable_sync_test;
  localparam int CFG_W = 6;
  localparam int DBG_W = 8;
  localparam int CTRL_W = CFG_W + 2;

  logic clk_bus = 1'b0, clk_core = 1'b0;
  logic rst_bus = 1'b1, rst_core = 1'b1;
  logic wr_ctrl = 1'b0, wr_dbg = 1'b0;
  logic [CTRL_W-1:0] wr_ctrl_data = '0;
  logic [DBG_W-1:0]  wr_dbg_data = '0;
  logic [CTRL_W-1:0] rd_ctrl;
  logic [DBG_W-1:0]  rd_dbg;
  logic busy_enable, busy_swrst, core_enable, core_swrst;

  always #2 clk_bus = ~clk_bus;
  always #3.5 clk_core = ~clk_core;

  ctl_enable_sync #(.CFG_W(CFG_W), .DBG_W(DBG_W)) uut (
    .clk_bus(clk_bus), .rst_bus(rst_bus), .wr_ctrl(wr_ctrl), .wr_ctrl_data(wr_ctrl_data),
    .wr_dbg(wr_dbg), .wr_dbg_data(wr_dbg_data), .rd_ctrl(rd_ctrl), .rd_dbg(rd_dbg),
    .busy_enable(busy_enable), .busy_swrst(busy_swrst), .clk_core(clk_core),
    .rst_core(rst_core), .core_enable(core_enable), .core_swrst(core_swrst)
  );

  int checks = 0, errors = 0, cyc = 0, pulses = 0;
  bit mon_on = 1'b0, done_flag = 1'b0;
  logic exp_en = 1'b0;
  logic [CFG_W-1:0] exp_cfg = '0;
  logic [DBG_W-1:0] exp_dbg = '0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // count core reset pulses away from the core edge
  always @(negedge clk_core) if (core_swrst) pulses++;

  // per-cycle comparison against the behavioural model (R2 R3 R6 R9)
  always @(negedge clk_bus) begin
    if (mon_on) begin
      chk("R2 enable readback", {31'b0, rd_ctrl[1]}, {31'b0, exp_en});
      chk("R3 config readback", {26'b0, rd_ctrl[CTRL_W-1:2]}, {26'b0, exp_cfg});
      chk("R6 reset bit vs busy", {31'b0, rd_ctrl[0]}, {31'b0, busy_swrst});
      chk("R9 debug readback", {24'b0, rd_dbg}, {24'b0, exp_dbg});
    end
  end

  always @(posedge clk_bus) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<20000", cyc);
      finish_run();
    end
  end

  task automatic write_ctrl(input logic [CTRL_W-1:0] d);
    logic ignored;
    @(negedge clk_bus);
    wr_ctrl = 1'b1;
    wr_ctrl_data = d;
    ignored = busy_swrst;
    @(posedge clk_bus);
    if (!ignored) begin
      if (d[0]) begin
        exp_en = 1'b0;
        exp_cfg = '0;
      end else begin
        if (!exp_en) exp_cfg = d[CTRL_W-1:2];
        exp_en = d[1];
      end
    end
  endtask

  task automatic write_dbg(input logic [DBG_W-1:0] d);
    @(negedge clk_bus);
    wr_dbg = 1'b1;
    wr_dbg_data = d;
    @(posedge clk_bus);
    exp_dbg = d;
    @(negedge clk_bus);
    wr_dbg = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_bus);
      wr_ctrl = 1'b0;
    end
  endtask

  task automatic wait_quiet(input string req);
    int n = 0;
    @(negedge clk_bus);
    wr_ctrl = 1'b0;
    while ((busy_enable || busy_swrst) && n < 60) begin
      @(negedge clk_bus);
      n++;
    end
    chk(req, {31'b0, (busy_enable || busy_swrst)}, 32'd0);
    idle(2);
  endtask

  initial begin
    int p0;
    repeat (6) @(posedge clk_core);
    @(negedge clk_bus);
    rst_bus = 1'b0;
    rst_core = 1'b0;
    // R1
    chk("R1 rd_ctrl", {24'b0, rd_ctrl}, 32'd0);
    chk("R1 rd_dbg", {24'b0, rd_dbg}, 32'd0);
    chk("R1 busy", {30'b0, busy_enable, busy_swrst}, 32'd0);
    chk("R1 core", {30'b0, core_enable, core_swrst}, 32'd0);
    mon_on = 1'b1;

    write_dbg(8'hA5);
    // R7: bit0 clear, config taken while disabled
    p0 = pulses;
    write_ctrl({6'h2A, 1'b0, 1'b0});
    @(negedge clk_bus);
    wr_ctrl = 1'b0;
    chk("R2 busy rises", {31'b0, busy_enable}, 32'd1);
    chk("R7 no reset busy", {31'b0, busy_swrst}, 32'd0);
    wait_quiet("R2 busy falls");
    chk("R7 no reset pulse", pulses, p0);
    chk("R2 core disabled", {31'b0, core_enable}, 32'd0);

    // R2 enable with new config
    write_ctrl({6'h15, 1'b1, 1'b0});
    @(negedge clk_bus);
    wr_ctrl = 1'b0;
    chk("R2 busy rises", {31'b0, busy_enable}, 32'd1);
    wait_quiet("R2 busy falls");
    chk("R2 core enabled", {31'b0, core_enable}, 32'd1);

    // R3 protected config while enabled
    write_ctrl({6'h3F, 1'b1, 1'b0});
    wait_quiet("R3 busy falls");
    chk("R3 cfg kept", {26'b0, rd_ctrl[CTRL_W-1:2]}, 32'h15);

    // R4 back-to-back, last value 0
    write_ctrl({6'h15, 1'b0, 1'b0});
    write_ctrl({6'h0C, 1'b1, 1'b0});
    write_ctrl({6'h33, 1'b0, 1'b0});
    @(negedge clk_bus);
    wr_ctrl = 1'b0;
    chk("R4 busy held", {31'b0, busy_enable}, 32'd1);
    wait_quiet("R4 busy falls");
    chk("R4 last value 0", {31'b0, core_enable}, 32'd0);

    // R4 back-to-back, last value 1
    write_ctrl({6'h01, 1'b0, 1'b0});
    write_ctrl({6'h02, 1'b1, 1'b0});
    wait_quiet("R4 busy falls");
    chk("R4 last value 1", {31'b0, core_enable}, 32'd1);

    // R5 R6 R8 software reset, other bits discarded, writes ignored during it
    p0 = pulses;
    write_ctrl({6'h3F, 1'b1, 1'b1});
    write_ctrl({6'h2B, 1'b1, 1'b0});
    @(negedge clk_bus);
    wr_ctrl = 1'b0;
    chk("R6 reset busy set", {31'b0, busy_swrst}, 32'd1);
    chk("R5 word after reset", {24'b0, rd_ctrl}, 32'd1);
    chk("R5 enable busy cleared", {31'b0, busy_enable}, 32'd0);
    wait_quiet("R6 reset completes");
    chk("R6 reset bit clear", {31'b0, rd_ctrl[0]}, 32'd0);
    chk("R8 write ignored", {24'b0, rd_ctrl}, 32'd0);
    chk("R5 core disabled", {31'b0, core_enable}, 32'd0);
    chk("R5 one pulse", pulses, p0 + 1);
    chk("R5 debug kept", {24'b0, rd_dbg}, 32'hA5);

    // R8 writes allowed again after completion
    write_ctrl({6'h07, 1'b1, 1'b0});
    wait_quiet("R8 busy falls");
    chk("R8 writable again", {31'b0, core_enable}, 32'd1);

    // R9 bus reset clears debug register
    mon_on = 1'b0;
    @(negedge clk_bus);
    rst_bus = 1'b1;
    rst_core = 1'b1;
    repeat (4) @(posedge clk_core);
    @(negedge clk_bus);
    rst_bus = 1'b0;
    rst_core = 1'b0;
    exp_en = 1'b0;
    exp_cfg = '0;
    exp_dbg = '0;
    chk("R9 debug cleared", {24'b0, rd_dbg}, 32'd0);
    chk("R1 word cleared", {24'b0, rd_ctrl}, 32'd0);
    idle(2);
    finish_run();
  end
endmodule